// File: doc/BRIEF.md
# Serial Instruction Clock-Count Guard

This block guards a serial memory interface against clock glitches. The front end reports each serial clock rising edge as a one-cycle strobe and flags the edge that samples the start bit. The guard counts edges from the start bit, which counts as the first, until the select line goes low. At that moment it compares the total with the exact length that the decoded instruction class requires.

A count that matches gives a one-cycle commit pulse, and any other count gives a one-cycle abort pulse. The memory controller acts on the commit pulse and drops the instruction on the abort pulse, so a frame lengthened or shortened by a glitch never changes stored data.

Page writes are valid only at the fixed overhead plus a whole number of data words, from one word up to the word limit. Read-type classes are not checked and produce no pulse. The block's ports carry plain control strobes, with no data stream and no back-pressure.

Top module: `clk_count_guard`

## Requirements
- R1: After reset, `commit_o` and `abort_o` are both low.
- R2: The strobe on `start_det_i` while `sel_i` is high sets the count to 1. Each later `sclk_rise_i` strobe while `sel_i` stays high adds 1. Clock strobes before the start strobe are not counted.
- R3: Class code 1 (single word or whole-array write) commits only when the count equals 3 + ADDR_W + DATA_W (27 with an 8-bit address, 25 with a 6-bit address). Any other count aborts.
- R4: Class code 2 (page write) commits when the count equals 3 + ADDR_W + N×DATA_W for a whole N from 1 to MAX_WORDS. Any other count aborts.
- R5: A page-write count that corresponds to zero words, or to more than MAX_WORDS words, aborts.
- R6: Class code 3 (data-less register and control instructions) commits only when the count equals 3 + ADDR_W (11 or 9). Any other count aborts.
- R7: Class codes 0 and 4 to 7 (reads) produce neither pulse.
- R8: If `sel_i` falls before any start strobe, neither pulse is produced.
- R9: The verdict pulse is high for exactly one cycle. It follows the first clock in which `sel_i` is sampled low after being high. Commit and abort are never high together.
- R10: The count clears while `sel_i` is low, so each selected frame is judged on its own edges only.
- R11: The count saturates at 2^CNT_W − 1 (255 with the default parameters) and never wraps. A frame of 283 edges in class 1 therefore aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip select level, synchronous to clk |
| sclk_rise_i | input | 1 | One-cycle strobe per serial clock rising edge |
| start_det_i | input | 1 | One-cycle strobe on the edge that samples the start bit |
| cls_i | input | 3 | Decoded instruction class, valid when select falls |
| commit_o | output | 1 | One-cycle pulse: frame length correct |
| abort_o | output | 1 | One-cycle pulse: frame length wrong |

## Verification
The bench builds two copies of the guard that share the same stimulus. One uses the default 8-bit address and the other a 6-bit address, both with 16-bit words and a four-word page. With both copies, every frame length that is right for one address width is a near-miss for the other. The 283-edge frame reaches the saturation point that the default counter width sets. The random frames cluster at header plus multiples of 16, plus or minus two edges, so both the page word limits and the off-by-one glitch lengths are exercised.

// File: rtl/ccv_pkg.sv
package ccv_pkg;
  localparam int CLS_W = 3;
  localparam logic [CLS_W-1:0] CLS_WORD = 3'd1;
  localparam logic [CLS_W-1:0] CLS_PAGE = 3'd2;
  localparam logic [CLS_W-1:0] CLS_CTRL = 3'd3;
  // start bit plus two opcode bits
  localparam int FRAME_PREFIX = 3;

  function automatic int cnt_width(int addr_w, int data_w, int max_words);
    return $clog2(FRAME_PREFIX + addr_w + max_words * data_w + 1) + 1;
  endfunction
endpackage

// File: rtl/ccv_edge_counter.sv
module ccv_edge_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             rise,
  input  logic             start,
  output logic [CNT_W-1:0] cnt,
  output logic             armed
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!sel) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!armed) begin
      if (start) begin
        cnt   <= CNT_ONE;
        armed <= 1'b1;
      end
    end else if (rise && cnt != CNT_MAX) begin
      cnt <= cnt + CNT_ONE;
    end
  end

  p_start_loads_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !armed && start) |=> (armed && cnt == CNT_ONE));

  p_clear_on_deselect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0 && !armed));

  p_no_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && $past(sel) && $past(armed)) |-> (cnt >= $past(cnt)));
endmodule

// File: rtl/ccv_expect.sv
module ccv_expect
  import ccv_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 4,
  parameter int CNT_W     = 8
) (
  input  logic [CLS_W-1:0] cls,
  input  logic [CNT_W-1:0] cnt,
  output logic             checked,
  output logic             match
);
  localparam logic [CNT_W-1:0] HDR_LEN  = CNT_W'(FRAME_PREFIX + ADDR_W);
  localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(FRAME_PREFIX + ADDR_W + DATA_W);
  localparam logic [CNT_W-1:0] WMAX     = CNT_W'(MAX_WORDS);
  localparam bit               D_POW2   = (DATA_W > 1) && ((DATA_W & (DATA_W - 1)) == 0);

  logic [CNT_W-1:0] body;
  logic [CNT_W-1:0] words;
  logic             rem_zero;
  logic             page_ok;

  assign body = cnt - HDR_LEN;

  generate
    if (D_POW2) begin : g_shift
      localparam int DLOG = $clog2(DATA_W);
      assign rem_zero = (body[DLOG-1:0] == '0);
      assign words    = body >> DLOG;
    end else begin : g_divide
      assign rem_zero = ((body % CNT_W'(DATA_W)) == '0);
      assign words    = body / CNT_W'(DATA_W);
    end
  endgenerate

  assign page_ok = (cnt >= WORD_LEN) && rem_zero && (words <= WMAX);

  always_comb begin
    checked = 1'b1;
    match   = 1'b0;
    unique case (cls)
      CLS_WORD: match = (cnt == WORD_LEN);
      CLS_PAGE: match = page_ok;
      CLS_CTRL: match = (cnt == HDR_LEN);
      default:  checked = 1'b0;
    endcase
  end
endmodule

// File: rtl/ccv_verdict.sv
module ccv_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic armed,
  input  logic checked,
  input  logic match,
  output logic commit_o,
  output logic abort_o
);
  logic sel_q;
  logic fall;

  assign fall = sel_q && !sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      commit_o <= 1'b0;
      abort_o  <= 1'b0;
    end else begin
      sel_q    <= sel;
      commit_o <= fall && armed && checked && match;
      abort_o  <= fall && armed && checked && !match;
    end
  end

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && abort_o));

  p_pulse_after_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o || abort_o) |-> !$past(sel));

  p_single_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o || abort_o) |=> !(commit_o || abort_o));

  p_unstarted_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !sel && !armed) |=> !(commit_o || abort_o));

  p_unchecked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && !sel && !checked) |=> !(commit_o || abort_o));
endmodule

// File: rtl/clk_count_guard.sv
module clk_count_guard
  import ccv_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_i,
  input  logic             sclk_rise_i,
  input  logic             start_det_i,
  input  logic [CLS_W-1:0] cls_i,
  output logic             commit_o,
  output logic             abort_o
);
  localparam int CNT_W = cnt_width(ADDR_W, DATA_W, MAX_WORDS);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             checked;
  logic             match;

  ccv_edge_counter #(.CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel_i),
    .rise  (sclk_rise_i),
    .start (start_det_i),
    .cnt   (cnt),
    .armed (armed)
  );

  ccv_expect #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_WORDS (MAX_WORDS),
    .CNT_W     (CNT_W)
  ) u_expect (
    .cls     (cls_i),
    .cnt     (cnt),
    .checked (checked),
    .match   (match)
  );

  ccv_verdict u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel_i),
    .armed    (armed),
    .checked  (checked),
    .match    (match),
    .commit_o (commit_o),
    .abort_o  (abort_o)
  );
endmodule

// File: tb/test_clk_count_guard.sv
module test_clk_count_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel = 1'b0;
  logic       rise = 1'b0;
  logic       start = 1'b0;
  logic [2:0] cls = 3'd0;
  logic       com8, abo8, com6, abo6;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  clk_count_guard #(.ADDR_W(8), .DATA_W(16), .MAX_WORDS(4)) i_clk_count_guard (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_rise_i(rise), .start_det_i(start),
    .cls_i(cls), .commit_o(com8), .abort_o(abo8));

  clk_count_guard #(.ADDR_W(6), .DATA_W(16), .MAX_WORDS(4)) i_clk_count_guard_a6 (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .sclk_rise_i(rise), .start_det_i(start),
    .cls_i(cls), .commit_o(com6), .abort_o(abo6));

  // {commit, abort} expected from the requirements
  function automatic logic [1:0] exp_pair(int c, int n, bit started, int aw);
    int hdr = 3 + aw;
    int k = (n > 255) ? 255 : n;  // R11 saturation
    bit ok;
    if (!started) return 2'b00;   // R8
    case (c)
      1: ok = (k == hdr + 16);                                                      // R3
      2: ok = (k >= hdr + 16) && ((k - hdr) % 16 == 0) && ((k - hdr) / 16 <= 4);    // R4 R5
      3: ok = (k == hdr);                                                           // R6
      default: return 2'b00;                                                        // R7
    endcase
    return ok ? 2'b10 : 2'b01;
  endfunction

  function automatic string tag_for(int c, bit started);
    if (!started) return "R8";
    case (c)
      1: return "R3";
      2: return "R4";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string tag, logic [1:0] got, logic [1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: {commit,abort} got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic pulse_edge(bit with_start);
    @(negedge clk);
    rise = 1'b1;
    start = with_start;
    @(negedge clk);
    rise = 1'b0;
    start = 1'b0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  // n = edges from the start bit onward (start counts as one)
  task automatic frame(int c, int n, int pre, bit started, string tag);
    @(negedge clk);
    sel = 1'b1;
    cls = 3'(c);
    for (int i = 0; i < pre; i++) pulse_edge(1'b0);   // R2 uncounted edges
    for (int i = 0; i < n; i++) pulse_edge(started && i == 0);
    @(negedge clk);
    sel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " a8"}, {com8, abo8}, exp_pair(c, n + (started ? 0 : pre), started, 8));
    check({tag, " a6"}, {com6, abo6}, exp_pair(c, n + (started ? 0 : pre), started, 6));
    @(negedge clk);
    check("R9 width", {com8, abo8, com6, abo6}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1 a8", {com8, abo8}, 2'b00);
    check("R1 a6", {com6, abo6}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post", {com8, abo8, com6, abo6}, 4'b0000);

    frame(1, 27, 0, 1'b1, "R3 exact");
    frame(1, 26, 0, 1'b1, "R3 short");
    frame(1, 28, 0, 1'b1, "R3 long");
    frame(1, 25, 0, 1'b1, "R3 six-bit");
    frame(2, 27, 0, 1'b1, "R4 one word");
    frame(2, 43, 0, 1'b1, "R4 two words");
    frame(2, 59, 0, 1'b1, "R4 three words");
    frame(2, 75, 0, 1'b1, "R4 four words");
    frame(2, 35, 0, 1'b1, "R4 partial");
    frame(2, 11, 0, 1'b1, "R5 zero words");
    frame(2, 91, 0, 1'b1, "R5 five words");
    frame(2, 89, 0, 1'b1, "R5 five words a6");
    frame(3, 11, 0, 1'b1, "R6 exact");
    frame(3, 9, 0, 1'b1, "R6 six-bit");
    frame(3, 12, 0, 1'b1, "R6 long");
    frame(0, 27, 0, 1'b1, "R7 read");
    frame(5, 11, 0, 1'b1, "R7 code5");
    frame(1, 27, 0, 1'b0, "R8 no start");
    frame(1, 27, 3, 1'b1, "R2 pre-start edges");
    frame(3, 11, 0, 1'b1, "R10 fresh frame");
    frame(1, 283, 0, 1'b1, "R11 saturate");

    for (int i = 0; i < 60; i++) begin
      int c = $urandom % 8;
      int hdr = ($urandom % 2) ? 11 : 9;
      int base = hdr + 16 * ($urandom % 6);
      int n = base + int'($urandom % 5) - 2;
      bit st = ($urandom % 10) != 0;
      frame(c, n, $urandom % 2, st, tag_for(c, st));
    end

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule